// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one programmable logic cell, of the kind repeated many times across a reconfigurable fabric. It keeps an 18-bit configuration word that is shifted in serially. The word holds two 3-input truth tables, a mode bit and an output-register bit. The cell has four logic inputs and a carry input. It drives a cell output and a carry output.

In normal mode, the two tables work together as one 4-input function. The top logic input picks which table's bit is used. In arithmetic mode, the two table outputs and the carry input feed a full adder. The adder gives a sum bit and a carry bit. The result from the selected mode is called the pre-output. It feeds a D flip-flop. The output-register bit decides whether the cell output is that flip-flop or the pre-output taken directly.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into bit 0 of the 18-bit configuration word, and every other bit moves one place up. After 18 shifts, sent MSB-first, the word is laid out as: bits 17..10 = table A, bits 9..2 = table B, bit 1 = arithmetic mode, bit 0 = registered output.
- R2: In normal mode (bit 1 = 0) with combinational output (bit 0 = 0), `cell_out` equals bit {lin[2],lin[1],lin[0]} of table A when lin[3] = 0, and the same bit of table B when lin[3] = 1. Index 0 is used when all three inputs are low.
- R3: In arithmetic mode (bit 1 = 1) with combinational output, `cell_out` is the XOR of table A's bit, table B's bit (both at index lin[2:0]) and `cin`. lin[3] has no effect.
- R4: In arithmetic mode, `cout` is the majority of table A's bit, table B's bit and `cin`.
- R5: In normal mode, `cout` is 0 for every input combination.
- R6: With the registered output selected (bit 0 = 1), `cell_out` shows the pre-output (the value described in R2 or R3) that was present at the previous rising clock edge. This is one cycle of latency.
- R7: A synchronous active-high `rst` clears the flip-flop to 0. A registered-mode `cell_out` therefore reads 0 after a reset edge.
- R8: `rst` leaves the configuration word unchanged. This holds even when the word is loaded while reset is asserted.
- R9: While `cfg_en` is low, `cfg_din` has no effect on the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock for the flip-flop and the configuration register |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| lin | input | 4 | Logic inputs; lin[3] selects between the tables in normal mode |
| cin | input | 1 | Carry input to the adder |
| cell_out | output | 1 | Cell output, registered or combinational |
| cout | output | 1 | Carry output, 0 in normal mode |

## Verification
If a configuration bit is wrong, it shows up on `cell_out` in the same cycle. This happens for exactly the input codes that index the corrupted table entry. A wrong mode bit shows up as a nonzero `cout` or as a sum that ignores lin[3]. Every configuration is therefore checked against all 32 combinations of `lin` and `cin`. A flip-flop that drops or delays its value shows up one cycle after the edge, as a mismatch against the pre-output from the previous cycle. A flip-flop that survives reset shows up at the first sample after the reset edge.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
package lut_cell_pkg;
    // number of shared select inputs of each table
    localparam int TBL_SEL  = 3;
    localparam int TBL_BITS = 1 << TBL_SEL;
    localparam int LIN_W    = TBL_SEL + 1;
    localparam int N_TBL    = 2;
    localparam int CFG_BITS = N_TBL * TBL_BITS + 2;

    // field order matters: first shifted bit lands in the top of tbl_a
    typedef struct packed {
        logic [TBL_BITS-1:0] tbl_a;
        logic [TBL_BITS-1:0] tbl_b;
        logic                arith;
        logic                use_ff;
    } cell_cfg_t;
endpackage

// File: rtl/lut_cell_cfg.sv
`timescale 1ns/1ps
module lut_cell_cfg #(
    parameter int W = lut_cell_pkg::CFG_BITS
) (
    input  logic         clk,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] word;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) begin
            s_d.word = {s_q.word[W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign word = s_q.word;
endmodule

// File: rtl/lut_cell_table.sv
`timescale 1ns/1ps
module lut_cell_table #(
    parameter int SEL_W = lut_cell_pkg::TBL_SEL,
    localparam int N_ENT = 1 << SEL_W
) (
    input  logic [N_ENT-1:0] tbl,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    always_comb begin
        bit_o = tbl[sel];
    end
endmodule

// File: rtl/lut_cell_fadd.sv
`timescale 1ns/1ps
module lut_cell_fadd (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic sum,
    output logic carry
);
    logic half_x;

    always_comb begin
        half_x = a ^ b;
        sum    = half_x ^ c;
        carry  = (a & b) | (half_x & c);
    end
endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LIN_W-1:0] lin,
    input  logic             cin,
    output logic             cell_out,
    output logic             cout
);
    typedef struct packed {
        logic ff;
    } cell_state_t;

    logic [CFG_BITS-1:0]            cfg_word;
    cell_cfg_t                      cfg;
    logic [N_TBL-1:0][TBL_BITS-1:0] tbls;
    logic [N_TBL-1:0]               tbl_bit;
    logic                           mux4_bit;
    logic                           add_sum;
    logic                           add_carry;
    logic                           pre;
    cell_state_t                    st_d, st_q;

    lut_cell_cfg #(.W(CFG_BITS)) u_cfg (
        .clk      (clk),
        .shift_en (cfg_en),
        .shift_in (cfg_din),
        .word     (cfg_word)
    );

    assign cfg     = cell_cfg_t'(cfg_word);
    assign tbls[0] = cfg.tbl_a;
    assign tbls[1] = cfg.tbl_b;

    for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
        lut_cell_table #(.SEL_W(TBL_SEL)) u_tbl (
            .tbl   (tbls[g]),
            .sel   (lin[TBL_SEL-1:0]),
            .bit_o (tbl_bit[g])
        );
    end

    lut_cell_fadd u_add (
        .a     (tbl_bit[0]),
        .b     (tbl_bit[1]),
        .c     (cin),
        .sum   (add_sum),
        .carry (add_carry)
    );

    always_comb begin
        // the top input joins the two halves into one 4-input function
        mux4_bit = lin[LIN_W-1] ? tbl_bit[1] : tbl_bit[0];
        pre      = cfg.arith ? add_sum : mux4_bit;
        st_d     = st_q;
        st_d.ff  = rst ? 1'b0 : pre;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        cell_out = cfg.use_ff ? st_q.ff : pre;
        cout     = cfg.arith ? add_carry : 1'b0;
    end
endmodule

// File: rtl/lut_cell_chk.sv
`timescale 1ns/1ps
module lut_cell_chk #(
    parameter int W = lut_cell_pkg::CFG_BITS
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_en,
    input logic         cfg_din,
    input logic         cin,
    input logic         cell_out,
    input logic         cout,
    input logic [W-1:0] cfg_word,
    input logic [1:0]   tbl_bit,
    input logic         pre
);
    AST_CFG_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_en) |-> cfg_word[0] == $past(cfg_din)); // R1
    AST_CFG_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_en) |-> cfg_word[W-1:1] == $past(cfg_word[W-2:0])); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_en) |-> $stable(cfg_word)); // R9
    AST_ARITH_SUM: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[1] && !cfg_word[0]) |-> cell_out == (tbl_bit[0] ^ tbl_bit[1] ^ cin)); // R3
    AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (rst)
        cfg_word[1] |-> cout == ((tbl_bit[0] & tbl_bit[1]) | (tbl_bit[0] & cin) | (tbl_bit[1] & cin))); // R4
    AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        !cfg_word[1] |-> cout == 1'b0); // R5
    AST_FF_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[0] && !$past(rst)) |-> cell_out == $past(pre)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cfg_word[0]) |-> cell_out == 1'b0); // R7
endmodule

bind lut_cell lut_cell_chk #(.W(lut_cell_pkg::CFG_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cin      (cin),
    .cell_out (cell_out),
    .cout     (cout),
    .cfg_word (cfg_word),
    .tbl_bit  (tbl_bit),
    .pre      (pre)
);

// File: tb/lut_cell_test.sv
`timescale 1ns/1ps
module lut_cell_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] lin = 4'd0;
    logic       cin = 1'b0;
    logic       cell_out;
    logic       cout;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural model state
    logic [7:0] m_a = 8'd0;
    logic [7:0] m_b = 8'd0;
    logic       m_arith = 1'b0;
    logic       m_reg = 1'b0;
    logic       m_ff = 1'b0;
    bit         m_ff_ok = 1'b0;

    lut_cell uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .lin      (lin),
        .cin      (cin),
        .cell_out (cell_out),
        .cout     (cout)
    );

    always #4 clk = ~clk;

    // returns {carry, pre-output}
    function automatic logic [1:0] ref_eval(logic [3:0] l, logic c);
        int idx;
        int s;
        idx = int'(l[2:0]);
        if (m_arith) begin
            s = int'(m_a[idx]) + int'(m_b[idx]) + int'(c);
            return {s > 1, (s % 2) == 1};
        end
        return {1'b0, l[3] ? m_b[idx] : m_a[idx]};
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (lin=%h cin=%b)", req, act, exp, lin, cin);
        end
    endtask

    task automatic step(logic [3:0] l, logic c, string req);
        logic [1:0] r;
        @(negedge clk);
        lin = l;
        cin = c;
        #1;
        r = ref_eval(l, c);
        check(m_arith ? "R4" : "R5", cout, r[1]);
        if (!m_reg) check(req, cell_out, r[0]);
        else if (m_ff_ok) check("R6", cell_out, m_ff);
        @(posedge clk);
        #1;
        m_ff = rst ? 1'b0 : r[0];
        m_ff_ok = 1'b1;
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 32; i++) begin
            step(4'(i), 1'(i >> 4), req);
        end
    endtask

    task automatic load(logic [17:0] w);
        for (int i = 17; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_din = w[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        m_a = w[17:10];
        m_b = w[9:2];
        m_arith = w[1];
        m_reg = w[0];
        m_ff_ok = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_ff = 1'b0;
        m_ff_ok = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        if (m_reg) check("R7", cell_out, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] t;
        repeat (3) @(posedge clk);
        // R8: load while in reset; R7: reset state of registered output
        load({8'h96, 8'h3C, 1'b0, 1'b1});
        #1;
        check("R7", cell_out, 1'b0);
        check("R5", cout, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        m_ff = 1'b0;
        m_ff_ok = 1'b1;
        sweep("R8");

        // directed: normal comb, table A only vs table B only
        load({8'hE8, 8'h17, 1'b0, 1'b0});
        sweep("R2");
        // directed: true adder (A = lin0, B = lin1)
        load({8'hAA, 8'hCC, 1'b1, 1'b0});
        sweep("R3");
        load({8'hAA, 8'hCC, 1'b1, 1'b1});
        sweep("R6");

        // random configurations in every mode / output combination
        for (int k = 0; k < 16; k++) begin
            t = 16'($urandom());
            load({t, 1'(k >> 1), 1'(k)});
            sweep(k[1] ? "R3" : "R2");
        end
        // R1: all-ones and all-zeros words reach every position
        load({8'hFF, 8'h00, 1'b0, 1'b0});
        sweep("R1");
        load({8'h00, 8'hFF, 1'b1, 1'b0});
        sweep("R1");

        // R9: cfg_din toggling with cfg_en low leaves config untouched
        load({8'h5A, 8'hC3, 1'b0, 1'b0});
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
        end
        sweep("R9");

        // R8 / R7: reset mid-run keeps configuration, clears flop
        load({8'h71, 8'h8E, 1'b1, 1'b1});
        sweep("R6");
        step(4'h7, 1'b1, "R6");
        pulse_reset();
        sweep("R8");
        load({8'h71, 8'h8E, 1'b0, 1'b0});
        pulse_reset();
        sweep("R8");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule